// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Suspend Flags

This block decides which of four DMA channels may run its next transfer when several raise requests together. A 2-bit mode field picks the ordering. Three of the codes give fixed rankings, and two of those rankings are deliberately not in numeric order. The fourth code gives a rotating scheme in which the channel that has just finished moves to last place. A grant is issued as a one-hot vector. It stays on the same channel until the transfer-done strobe arrives. A new decision is made only while no grant is outstanding.

The same control/status register holds two sticky suspend flags. One records a bus address fault and the other records a non-maskable interrupt event. While either flag is set, no new grant is issued. The CPU cannot set a flag. To clear a flag, the CPU must first read the register and see the flag at 1, and its next write must carry 0 in that flag's bit. This prevents a blind write from discarding an event that software has not yet seen. The datapath, the address counters and the bus cycles are handled elsewhere.

Top module: `dma_prio_arb`

## Requirements
- R1: `gnt_o` is one-hot or zero. A grant is issued only to a channel whose request was high at the deciding edge, and only while no grant is outstanding. It holds until a clock edge that sees `done_i`, and is zero in the cycle after that edge. A `done_i` with no grant outstanding has no effect.
- R2: Mode code 00, the reset value, ranks the channels 0, 1, 2, 3, highest first.
- R3: Mode code 01 ranks the channels 0, 2, 3, 1.
- R4: Mode code 10 ranks the channels 2, 0, 1, 3.
- R5: Mode code 11 rotates the ranking. Channel 0 is highest after reset. When the transfer of channel k completes, channel (k+1) mod 4 becomes highest and the others follow in increasing index order. The rotation point advances on every completed transfer in any mode, and never on an idle `done_i`.
- R6: The register layout is as follows. Bits 9:8 hold the mode and are written by every write. Bit 2 is the address-fault flag and bit 1 is the interrupt flag. Every other bit reads 0, and writes to it have no effect. After reset the register reads 0x0000.
- R7: `addr_err_i` sets bit 2 at the next edge and `nmi_i` sets bit 1 at the next edge. This holds whatever the state of the arbiter and of the other flag.
- R8: While either flag is set, no new grant is issued. A grant that is already outstanding is kept until `done_i`.
- R9: Writing 1 to a flag bit never sets it. A write of 0 clears a flag only if the most recent register access before that write was a read that returned the flag as 1. A write of 0 with no such read leaves the flag set.
- R10: A read that returns a flag as 1 arms only the single next write. If that write carries a 1 in the flag bit, the arming is used up, and a later write of 0 does not clear the flag.
- R11: If a hardware set event arrives in the same cycle as an armed write of 0, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Transfer request, one bit per channel |
| done_i | input | 1 | Strobe marking the end of the granted transfer |
| addr_err_i | input | 1 | Address fault event; sets the bit 2 flag |
| nmi_i | input | 1 | Non-maskable interrupt event; sets the bit 1 flag |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read, qualified by cpu_sel_i |
| cpu_wdata_i | input | 16 | Register write data |
| cpu_rdata_o | output | 16 | Register read data |
| gnt_o | output | 4 | One-hot grant |

## Verification
Each fixed mode is driven with request masks that leave out the higher-ranked channels one by one. Each mask's winner differs between at least two of the three orderings, so the test detects a swapped rank as well as a wrong mode decode. In rotate mode, all four channels request continuously, and the bench checks that the grant moves 0, 1, 2, 3 and then wraps. Sparse masks then confirm that the search wraps past channel 3, and an idle done strobe confirms that it does not move the rotation point. The flag sequences issue a blind zero write, a read followed by a write of one, a read followed by a set event that collides with the clearing write, and a set event while a grant is outstanding. Together these separate the arming, the consumption of the arming and the set priority.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned N_CH     = 4;
  localparam int unsigned CH_W     = $clog2(N_CH);
  localparam int unsigned REG_W    = 16;
  localparam int unsigned MODE_LSB = 8;
  localparam int unsigned FLAG_LSB = 1;  // bit 1: interrupt flag, bit 2: address flag
  localparam int unsigned N_FLAG   = 2;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_SKEW_A = 2'b01,
    MODE_SKEW_B = 2'b10,
    MODE_ROTATE = 2'b11
  } arb_mode_e;

  // channel occupying a given rank (0 = highest)
  function automatic logic [CH_W-1:0] rank_to_ch(arb_mode_e m, logic [CH_W-1:0] rank,
                                                 logic [CH_W-1:0] head);
    logic [CH_W-1:0] ch;
    unique case (m)
      MODE_LINEAR: ch = rank;
      MODE_SKEW_A: ch = (rank == 2'd0) ? 2'd0 : (rank == 2'd1) ? 2'd2 :
                        (rank == 2'd2) ? 2'd3 : 2'd1;
      MODE_SKEW_B: ch = (rank == 2'd0) ? 2'd2 : (rank == 2'd1) ? 2'd0 :
                        (rank == 2'd2) ? 2'd1 : 2'd3;
      default:     ch = head + rank;
    endcase
    return ch;
  endfunction

  function automatic logic [CH_W-1:0] oh_to_idx(logic [N_CH-1:0] oh);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_CH; i++) if (oh[i]) idx = CH_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/dma_arb_flag.sv
module dma_arb_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                          flag_q <= 1'b1;  // event wins over clear
      else if (wr_i && arm_q && !wbit_i)  flag_q <= 1'b0;
      if (wr_i)                           arm_q  <= 1'b0;  // any write consumes arming
      else if (rd_i && flag_q)            arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dma_arb_csr.sv
module dma_arb_csr
  import dma_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_sel_i,
  input  logic             cpu_we_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  input  logic             addr_err_i,
  input  logic             nmi_i,
  output arb_mode_e        mode_o,
  output logic             suspend_o,
  output logic [REG_W-1:0] rdata_o
);
  logic             rd, wr;
  arb_mode_e        mode_q;
  logic [N_FLAG-1:0] set_vec, flag_vec;

  assign rd      = cpu_sel_i && !cpu_we_i;
  assign wr      = cpu_sel_i &&  cpu_we_i;
  assign set_vec = {addr_err_i, nmi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_q <= MODE_LINEAR;
    else if (wr)  mode_q <= arb_mode_e'(cpu_wdata_i[MODE_LSB +: 2]);
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    dma_arb_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .rd_i   (rd),
      .wr_i   (wr),
      .wbit_i (cpu_wdata_i[FLAG_LSB+g]),
      .flag_o (flag_vec[g])
    );
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[MODE_LSB +: 2]         = mode_q;
    rdata_o[FLAG_LSB +: N_FLAG]    = flag_vec;
  end

  assign mode_o    = mode_q;
  assign suspend_o = |flag_vec;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  logic [N_CH-1:0] req_i,
  input  arb_mode_e       mode_i,
  input  logic [CH_W-1:0] head_i,
  output logic            valid_o,
  output logic [N_CH-1:0] pick_o
);
  logic [CH_W-1:0] ch;

  always_comb begin
    pick_o  = '0;
    valid_o = 1'b0;
    ch      = '0;
    for (int r = 0; r < N_CH; r++) begin
      ch = rank_to_ch(mode_i, CH_W'(r), head_i);
      if (!valid_o && req_i[ch]) begin
        pick_o[ch] = 1'b1;
        valid_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  req_i,
  input  logic             done_i,
  input  logic             addr_err_i,
  input  logic             nmi_i,
  input  logic             cpu_sel_i,
  input  logic             cpu_we_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  output logic [REG_W-1:0] cpu_rdata_o,
  output logic [N_CH-1:0]  gnt_o
);
  arb_mode_e       mode;
  logic            suspend, pick_valid;
  logic [N_CH-1:0] pick, gnt_q;
  logic [CH_W-1:0] head_q;

  dma_arb_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_sel_i   (cpu_sel_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_wdata_i (cpu_wdata_i),
    .addr_err_i  (addr_err_i),
    .nmi_i       (nmi_i),
    .mode_o      (mode),
    .suspend_o   (suspend),
    .rdata_o     (cpu_rdata_o)
  );

  dma_arb_pick u_pick (
    .req_i   (req_i),
    .mode_i  (mode),
    .head_i  (head_q),
    .valid_o (pick_valid),
    .pick_o  (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      head_q <= '0;
    end else if (|gnt_q) begin
      if (done_i) begin
        gnt_q  <= '0;
        head_q <= oh_to_idx(gnt_q) + 1'b1;
      end
    end else if (!suspend && pick_valid) begin
      gnt_q <= pick;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  req_i,
  input logic             done_i,
  input logic             addr_err_i,
  input logic             nmi_i,
  input logic [REG_W-1:0] cpu_rdata_o,
  input logic [N_CH-1:0]  gnt_o
);
  logic ae, nf;
  assign ae = cpu_rdata_o[FLAG_LSB+1];
  assign nf = cpu_rdata_o[FLAG_LSB];

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R1
  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o && !done_i) |=> (gnt_o == $past(gnt_o))); // R1
  AST_GNT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o && done_i) |=> (gnt_o == '0)); // R1
  AST_GNT_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> ((gnt_o & ~$past(req_i)) == '0)); // R1
  AST_NO_GNT_SUSPENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o == '0) && (ae || nf)) |=> (gnt_o == '0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rdata_o[REG_W-1:MODE_LSB+2] == '0) && (cpu_rdata_o[MODE_LSB-1:FLAG_LSB+N_FLAG] == '0)
    && !cpu_rdata_o[0]); // R6
  AST_AE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_i |=> ae); // R7, R11
  AST_NMI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> nf); // R7, R11
  AST_AE_NO_CPU_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ae && !addr_err_i) |=> !ae); // R9
  AST_NMI_NO_CPU_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nf && !nmi_i) |=> !nf); // R9
endmodule

bind dma_prio_arb dma_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .done_i      (done_i),
  .addr_err_i  (addr_err_i),
  .nmi_i       (nmi_i),
  .cpu_rdata_o (cpu_rdata_o),
  .gnt_o       (gnt_o)
);

// File: tb/dma_prio_arb_test.sv
`timescale 1ns/1ps
module dma_prio_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        done = 1'b0, ae_ev = 1'b0, nmi_ev = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  gnt;
  int n_vec = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dma_prio_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .addr_err_i(ae_ev), .nmi_i(nmi_ev), .cpu_sel_i(sel), .cpu_we_i(we),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .gnt_o(gnt)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    sel = 1'b1; we = 1'b1; wdata = v; tick();
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(output logic [15:0] v);
    sel = 1'b1; we = 1'b0; v = rdata; tick();
    sel = 1'b0;
  endtask

  task automatic pulse_ae();  ae_ev = 1'b1;  tick(); ae_ev = 1'b0;  endtask
  task automatic pulse_nmi(); nmi_ev = 1'b1; tick(); nmi_ev = 1'b0; endtask

  task automatic xfer(input string tag, input logic [3:0] mask, input logic [3:0] exp);
    req = mask; tick();
    chk({tag, " grant"}, 16'(gnt), 16'(exp));
    done = 1'b1; tick(); done = 1'b0; req = '0;
    chk({"R1 release after ", tag}, 16'(gnt), 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R6 reset rdata", rdata, 16'h0000);
    chk("R1 reset grant", 16'(gnt), 16'h0);
    wr(16'hFFFF); rd(v);
    chk("R6/R9 write all ones", v, 16'h0300);
    wr(16'h0000); rd(v);
    chk("R6 mode back to 00", v, 16'h0000);
  endtask

  task automatic t_linear();
    wr(16'h0000);
    xfer("R2 mask 1111", 4'b1111, 4'b0001);
    xfer("R2 mask 1110", 4'b1110, 4'b0010);
    xfer("R2 mask 1100", 4'b1100, 4'b0100);
    xfer("R2 mask 1000", 4'b1000, 4'b1000);
  endtask

  task automatic t_skew_a();
    wr(16'h0100);
    xfer("R3 mask 1111", 4'b1111, 4'b0001);
    xfer("R3 mask 1110", 4'b1110, 4'b0100);
    xfer("R3 mask 1010", 4'b1010, 4'b1000);
    xfer("R3 mask 0010", 4'b0010, 4'b0010);
  endtask

  task automatic t_skew_b();
    wr(16'h0200);
    xfer("R4 mask 1111", 4'b1111, 4'b0100);
    xfer("R4 mask 1011", 4'b1011, 4'b0001);
    xfer("R4 mask 1010", 4'b1010, 4'b0010);
    xfer("R4 mask 1000", 4'b1000, 4'b1000);
  endtask

  task automatic t_rotate();
    wr(16'h0300);
    xfer("R5 align on ch3", 4'b1000, 4'b1000);
    xfer("R5 rot ch0", 4'b1111, 4'b0001);
    done = 1'b1; tick(); done = 1'b0;  // idle done: no effect
    chk("R1 idle done no grant", 16'(gnt), 16'h0);
    xfer("R5 rot ch1 after idle done", 4'b1111, 4'b0010);
    xfer("R5 rot ch2", 4'b1111, 4'b0100);
    xfer("R5 rot ch3", 4'b1111, 4'b1000);
    xfer("R5 rot wrap ch0", 4'b1111, 4'b0001);
    xfer("R5 sparse skip to ch2", 4'b0101, 4'b0100);
    xfer("R5 sparse wrap to ch0", 4'b0101, 4'b0001);
    wr(16'h0000);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    pulse_ae();
    wr(16'h0000); rd(v);
    chk("R9 blind zero write keeps flag / R7 set", v, 16'h0004);
    req = 4'b0001; tick();
    chk("R8 no grant while suspended", 16'(gnt), 16'h0);
    req = '0;
    wr(16'h0004); wr(16'h0000); rd(v);
    chk("R10 arming consumed by one-write", v, 16'h0004);
    wr(16'h0000); rd(v);
    chk("R9 read-then-zero clears", v, 16'h0000);
    pulse_ae(); rd(v);
    sel = 1'b1; we = 1'b1; wdata = '0; ae_ev = 1'b1; tick();
    sel = 1'b0; we = 1'b0; ae_ev = 1'b0;
    rd(v);
    chk("R11 set event beats clear", v, 16'h0004);
    pulse_nmi(); rd(v);
    chk("R7 nmi sets while suspended", v, 16'h0006);
    wr(16'h0000); rd(v);
    chk("R9 both cleared", v, 16'h0000);
  endtask

  task automatic t_held();
    logic [15:0] v;
    req = 4'b0001; tick();
    chk("R1 grant ch0", 16'(gnt), 16'h0001);
    pulse_nmi();
    chk("R8 held grant survives flag", 16'(gnt), 16'h0001);
    done = 1'b1; tick(); done = 1'b0;
    chk("R1 released", 16'(gnt), 16'h0);
    req = 4'b0010; tick();
    chk("R8 new grant blocked", 16'(gnt), 16'h0);
    rd(v);
    chk("R7 nmi flag", v, 16'h0002);
    wr(16'h0000);
    chk("R8 still blocked at clear edge", 16'(gnt), 16'h0);
    tick();
    chk("R8 grant after clear", 16'(gnt), 16'h0002);
    done = 1'b1; tick(); done = 1'b0; req = '0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_linear();
    t_skew_a();
    t_skew_b();
    t_rotate();
    t_flags();
    t_held();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_vec++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule